// File: doc/BRIEF.md
# RTC Interrupt Flag and Power-Control Status Register

This block is the combined event-flag and power-control status register of a real-time-clock peripheral. It sits on an asynchronous parallel bus with active-low chip enable, output enable and write enable, plus address lines. The bus signals are already synchronised to the system clock. The block latches three event flags: an alarm match, a kickstart event and a watchdog timeout. Each flag comes from outside as a one-cycle strobe. The block combines the flags with their enable levels into an interrupt request bit and an active-low interrupt output.

The flags clear in two ways. The first is a write of zero. The second is a read that is qualified: the register address must stay selected, with enables asserted, for a minimum number of clock cycles. The clear is committed when that access ends. Data returned during the read therefore always shows the flags as they stood before the clear.

The register also holds a reset-select bit and a power-active-bar bit, which together steer an open-drain power pin. Two read-only inputs report the battery state. The power-active-bar bit is forced low when the alarm fires with the alarm power enable set, or when a kickstart flag is pending.

Top module: `rtc_flag_reg`

## Requirements
- R1: While the register is read (chip enable, output enable low, write enable high, address equal to FLAG_ADDR), the read data is {batt_main, batt_aux, reset select, power-active-bar, alarm flag, kickstart flag, watchdog flag, interrupt bit}, most significant bit first. At all other times the read data is 0.
- R2: The interrupt bit (bit 0) is (alarm flag AND alarm_ie) OR (kickstart flag AND kick_ie) OR (watchdog flag AND wdog_ie). irq_n is low exactly when that bit is 1.
- R3: An event strobe sets its flag at the next clock edge. When a strobe and a clear meet in the same cycle, the flag stays set.
- R4: A read held for at least QUAL_CYC consecutive cycles clears all three flags at the clock edge after the access ends. The access ends when any enable rises or the address changes. The data returned during that read shows the flags before the clear.
- R5: A read held for fewer than QUAL_CYC cycles clears no flag.
- R6: A write to FLAG_ADDR clears each of bits 3..1 that is written as 0. Writing 1 to bit 2 sets the kickstart flag. Writing 1 to bit 3 or bit 1 leaves those flags unchanged. A write to any other address leaves all flags unchanged.
- R7: Bits 5 (reset select) and 4 (power-active-bar) take the written value. Writes to bits 7, 6 and 0 have no effect. Bits 7 and 6 always follow the battery inputs.
- R8: The power-active-bar bit is forced to 0 one edge after the register holds (alarm flag AND alarm_pwr_en) or the kickstart flag. This force takes priority over a write of 1.
- R9: pwr_drive (1 = pull the power pin low) is 1 when power-active-bar is 0 and either reset select is 1 or pwr_fail is 0. Otherwise it is 0 (high impedance).
- R10: After reset, the flags and reset select are 0, power-active-bar is 1, and irq_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected for read |
| alarm_hit | input | 1 | One-cycle alarm match strobe |
| kick_hit | input | 1 | One-cycle kickstart strobe |
| wdog_hit | input | 1 | One-cycle watchdog timeout strobe |
| alarm_ie | input | 1 | Alarm interrupt enable |
| kick_ie | input | 1 | Kickstart interrupt enable |
| wdog_ie | input | 1 | Watchdog interrupt enable |
| alarm_pwr_en | input | 1 | Alarm may force power-active-bar low |
| pwr_fail | input | 1 | Main supply failure indication |
| batt_main | input | 1 | Main backup battery low |
| batt_aux | input | 1 | Auxiliary backup battery low |
| irq_n | output | 1 | Interrupt output, active low |
| pwr_drive | output | 1 | 1 drives the power pin low, 0 leaves it floating |

## Verification
The interrupt combine is driven from a table that pairs flag patterns with enable patterns. These include one flag with its own enable, one flag with only foreign enables, all flags with no enables, and mixed pairs. The table tells a correct AND-OR apart from a swapped enable or a missing term. Reads are tried at one cycle below the qualifying length, at the qualifying length ending by an enable rise, and at the qualifying length ending by an address change. Comparing flags before and after each of these separates the counter threshold from the end-of-access commit. Write patterns with mixed ones and zeros, and a write to a foreign address, separate clear-by-zero, set-by-one and ignored bits. Strobes placed on the commit cycle, and writes of power-active-bar against a pending force, probe the priority rules.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;

  localparam int NFLAG = 3;

  // index into the flag vector, which sits on status bits 3..1
  localparam int FL_WDOG  = 0;
  localparam int FL_KICK  = 1;
  localparam int FL_ALARM = 2;

  // which flags software may set by writing 1
  localparam logic [NFLAG-1:0] SW_SET_MASK = 3'b010;

  // status bit positions
  localparam int B_BATT_M = 7;
  localparam int B_BATT_A = 6;
  localparam int B_RSEL   = 5;
  localparam int B_PAB    = 4;
  localparam int B_FLAG_L = 1;
  localparam int B_IRQ    = 0;

  function automatic logic irq_combine(input logic [NFLAG-1:0] flg,
                                       input logic [NFLAG-1:0] ena);
    return |(flg & ena);
  endfunction

  function automatic logic pab_force(input logic alarm_f, input logic tpe,
                                     input logic kick_f);
    return (alarm_f & tpe) | kick_f;
  endfunction

  function automatic logic pwr_pull_low(input logic pab, input logic rsel,
                                        input logic fail);
    return ~pab & (rsel | ~fail);
  endfunction

  function automatic logic [7:0] pack_status(input logic bm, input logic ba,
                                             input logic rsel, input logic pab,
                                             input logic [NFLAG-1:0] flg,
                                             input logic irq);
    logic [7:0] s;
    s = '0;
    s[B_BATT_M] = bm;
    s[B_BATT_A] = ba;
    s[B_RSEL]   = rsel;
    s[B_PAB]    = pab;
    s[B_FLAG_L +: NFLAG] = flg;
    s[B_IRQ]    = irq;
    return s;
  endfunction

endpackage

// File: rtl/rtc_read_qual.sv
module rtc_read_qual #(
  parameter int QUAL_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic read_sel,
  output logic armed,
  output logic commit
);
  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_CYC);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (!read_sel)
      hold_cnt <= '0;
    else if (hold_cnt != LIMIT)
      hold_cnt <= hold_cnt + 1'b1;
  end

  assign armed  = (hold_cnt == LIMIT);
  assign commit = armed & ~read_sel;

  // commit only fires in the first idle cycle after a held read
  AST_COMMIT_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(read_sel)); // R4
  AST_NO_IDLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!read_sel && $past(!read_sel)) |-> !commit); // R5

endmodule

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell #(
  parameter bit SW_SET = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd_clr,
  input  logic wr_en,
  input  logic wr_bit,
  output logic q
);
  logic clr_req, set_req;

  assign clr_req = rd_clr | (wr_en & ~wr_bit);
  assign set_req = evt | (SW_SET & wr_en & wr_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set_req | (q & ~clr_req);
  end

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> q); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !evt && !wr_en) |=> !q); // R4

endmodule

// File: rtl/rtc_flag_reg.sv
module rtc_flag_reg
  import rtc_flag_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 14,
  parameter int QUAL_CYC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              alarm_hit,
  input  logic              kick_hit,
  input  logic              wdog_hit,
  input  logic              alarm_ie,
  input  logic              kick_ie,
  input  logic              wdog_ie,
  input  logic              alarm_pwr_en,
  input  logic              pwr_fail,
  input  logic              batt_main,
  input  logic              batt_aux,
  output logic              irq_n,
  output logic              pwr_drive
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(FLAG_ADDR);

  logic addr_hit, read_sel, write_sel;
  logic armed, rd_commit;
  logic [NFLAG-1:0] evt_vec, ena_vec, flags;
  logic rsel_q, pab_q, irq_bit, force_pab;

  assign addr_hit  = (bus_addr == MY_ADDR) & ~bus_ce_n;
  assign read_sel  = addr_hit & ~bus_oe_n & bus_we_n;
  assign write_sel = addr_hit & ~bus_we_n;

  assign evt_vec = {alarm_hit, kick_hit, wdog_hit};
  assign ena_vec = {alarm_ie, kick_ie, wdog_ie};

  rtc_read_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .read_sel (read_sel),
    .armed    (armed),
    .commit   (rd_commit)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    rtc_flag_cell #(.SW_SET(SW_SET_MASK[i])) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt    (evt_vec[i]),
      .rd_clr (rd_commit),
      .wr_en  (write_sel),
      .wr_bit (bus_wdata[B_FLAG_L + i]),
      .q      (flags[i])
    );
  end

  assign force_pab = pab_force(flags[FL_ALARM], alarm_pwr_en, flags[FL_KICK]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel_q <= 1'b0;
      pab_q  <= 1'b1;
    end else begin
      if (write_sel) rsel_q <= bus_wdata[B_RSEL];
      if (force_pab)      pab_q <= 1'b0;
      else if (write_sel) pab_q <= bus_wdata[B_PAB];
    end
  end

  assign irq_bit   = irq_combine(flags, ena_vec);
  assign irq_n     = ~irq_bit;
  assign pwr_drive = pwr_pull_low(pab_q, rsel_q, pwr_fail);
  assign bus_rdata = read_sel ? pack_status(batt_main, batt_aux, rsel_q, pab_q,
                                            flags, irq_bit) : 8'h00;

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> irq_n); // R2
  AST_KICK_DROPS_PAB: assert property (@(posedge clk) disable iff (!rst_n)
    kick_hit |-> ##2 !pab_q); // R8
  AST_BATT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    read_sel |-> (bus_rdata[7:6] == {batt_main, batt_aux})); // R7
  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !read_sel |-> (bus_rdata == 8'h00)); // R1
  AST_ARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && read_sel) |=> armed || !read_sel); // R4

endmodule

// File: tb/rtc_flag_reg_test.sv
module rtc_flag_reg_test;
  localparam logic [3:0] FA = 4'hE;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1, oe_n = 1, we_n = 1;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic a_hit = 0, k_hit = 0, w_hit = 0;
  logic a_ie = 0, k_ie = 0, w_ie = 0, tpe = 0, pfail = 0;
  logic bm = 1, ba = 0;
  logic irq_n, pdrv;
  int n_chk = 0, n_err = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  rtc_flag_reg uut (
    .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .alarm_hit(a_hit), .kick_hit(k_hit), .wdog_hit(w_hit),
    .alarm_ie(a_ie), .kick_ie(k_ie), .wdog_ie(w_ie), .alarm_pwr_en(tpe),
    .pwr_fail(pfail), .batt_main(bm), .batt_aux(ba), .irq_n(irq_n), .pwr_drive(pdrv)
  );

  // stimulus: events {alarm,kick,wdog}, enables {alarm,kick,wdog}, expected irq_n
  typedef struct packed { logic [2:0] ev; logic [2:0] ie; logic irqn; } vec_t;
  localparam vec_t VECS [8] = '{
    '{3'b100, 3'b100, 1'b0}, '{3'b100, 3'b011, 1'b1},
    '{3'b010, 3'b010, 1'b0}, '{3'b001, 3'b001, 1'b0},
    '{3'b001, 3'b110, 1'b1}, '{3'b111, 3'b000, 1'b1},
    '{3'b110, 3'b001, 1'b1}, '{3'b011, 3'b101, 1'b0}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 0; we_n = 0; addr = a; wdata = d;
    @(negedge clk); ce_n = 1; we_n = 1; #1;
  endtask

  // read held for n cycles; returns data seen in the first cycle
  task automatic bus_read(input int n, output logic [7:0] d);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = FA; #1 d = rdata;
    repeat (n) @(negedge clk);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic peek(output logic [7:0] d);
    bus_read(1, d);
    #1;
  endtask

  task automatic pulse(input logic [2:0] ev);
    @(negedge clk); {a_hit, k_hit, w_hit} = ev;
    @(negedge clk); {a_hit, k_hit, w_hit} = 3'b000; #1;
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R10 / R1 reset state
    chk("R10 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R10 pwr_drive", {7'd0, pdrv}, 8'h00);
    chk("R1 idle rdata", rdata, 8'h00);
    peek(rd);
    chk("R10 reset status", rd, 8'h90);

    // R2 table walk
    for (int i = 0; i < 8; i++) begin
      bus_write(FA, 8'h00);
      {a_ie, k_ie, w_ie} = VECS[i].ie;
      pulse(VECS[i].ev);
      chk("R2 irq_n", {7'd0, irq_n}, {7'd0, VECS[i].irqn});
      peek(rd);
      chk("R3 flags latched", {5'd0, rd[3:1]}, {5'd0, VECS[i].ev});
      chk("R2 irq bit", {7'd0, rd[0]}, {7'd0, ~VECS[i].irqn});
    end

    // R4 qualified read ending by enable rise
    {a_ie, k_ie, w_ie} = 3'b111;
    bus_write(FA, 8'h00);
    pulse(3'b111);
    bus_read(2, rd);
    chk("R4 pre-clear data", {5'd0, rd[3:1]}, 8'h07);
    @(negedge clk); #1;
    chk("R4 irq released", {7'd0, irq_n}, 8'h01);
    peek(rd);
    chk("R4 flags cleared", {5'd0, rd[3:1]}, 8'h00);

    // R4 qualified read ending by address change
    pulse(3'b100);
    @(negedge clk); ce_n = 0; oe_n = 0; addr = FA;
    repeat (2) @(negedge clk);
    addr = 4'h0;
    @(negedge clk); ce_n = 1; oe_n = 1;
    peek(rd);
    chk("R4 addr change clears", {5'd0, rd[3:1]}, 8'h00);

    // R5 short read
    pulse(3'b010);
    bus_read(1, rd);
    @(negedge clk); #1;
    peek(rd);
    chk("R5 short read keeps", {5'd0, rd[3:1]}, 8'h02);

    // R3 event in commit cycle wins
    bus_write(FA, 8'h00);
    pulse(3'b100);
    bus_read(2, rd);
    a_hit = 1;
    @(negedge clk); a_hit = 0; #1;
    peek(rd);
    chk("R3 event beats clear", {5'd0, rd[3:1]}, 8'h04);

    // R6 writes
    bus_write(FA, 8'h00);
    bus_write(FA, 8'h0E);
    peek(rd);
    chk("R6 write sets only kick", {5'd0, rd[3:1]}, 8'h02);
    pulse(3'b101);
    bus_write(FA, 8'h06);
    peek(rd);
    chk("R6 mixed write", {5'd0, rd[3:1]}, 8'h03);
    bus_write(4'h0, 8'h00);
    peek(rd);
    chk("R6 foreign addr ignored", {5'd0, rd[3:1]}, 8'h03);
    bus_write(FA, 8'h00);
    peek(rd);
    chk("R6 zero clears", {5'd0, rd[3:1]}, 8'h00);

    // R7 read-only and writable control bits
    {a_ie, k_ie, w_ie} = 3'b000;
    bm = 0; ba = 0;
    bus_write(FA, 8'hF1);
    bm = 1; ba = 0;
    peek(rd);
    chk("R7 control and ro bits", rd, 8'hB0);
    bm = 0; ba = 1;
    peek(rd);
    chk("R7 battery follows", rd, 8'h70);

    // R8 power-active-bar force
    tpe = 0;
    pulse(3'b100);
    peek(rd);
    chk("R8 no force without tpe", {7'd0, rd[4]}, 8'h01);
    tpe = 1;
    peek(rd);
    chk("R8 alarm+tpe forces", {7'd0, rd[4]}, 8'h00);
    bus_write(FA, 8'h1A);
    peek(rd);
    chk("R8 force beats write", {7'd0, rd[4]}, 8'h00);
    tpe = 0;
    bus_write(FA, 8'h10);
    peek(rd);
    chk("R8 write restores", {7'd0, rd[4]}, 8'h01);
    pulse(3'b010);
    peek(rd);
    chk("R8 kick forces", {7'd0, rd[4]}, 8'h00);

    // R9 power pin
    bus_write(FA, 8'h00);
    pfail = 0; #1;
    chk("R9 active, no fail", {7'd0, pdrv}, 8'h01);
    pfail = 1; #1;
    chk("R9 fail floats", {7'd0, pdrv}, 8'h00);
    bus_write(FA, 8'h20);
    chk("R9 rsel keeps drive", {7'd0, pdrv}, 8'h01);
    bus_write(FA, 8'h30);
    chk("R9 pab floats", {7'd0, pdrv}, 8'h00);
    chk("R1 idle after writes", rdata, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule